// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character per host request into a frame on a single transmit line. A frame is a low start bit, then 5 to 9 data bits sent least significant first, then an optional parity bit, then one or two high stop bits. The data width, parity mode and stop-bit count are chosen at run time through static configuration inputs. The host offers a character with a valid/ready handshake. An external baud-tick enable moves the line on by exactly one bit time per tick.

The block accepts a character while idle, or during the final stop bit of the frame in flight. It holds that character together with a copy of the format, and it starts the frame on the next tick. When a character is waiting at the end of a frame, its start bit follows the last stop bit directly, so the frames run back to back with no idle bit between them. When nothing is waiting, the line rests high.

Top module: `async_tx`

## Requirements
- R1: Every frame begins with one bit time of the line driven low. A character accepted on a cycle where `bit_tick` is high has its start bit on the line from that clock edge onward. A character accepted on any other cycle starts at the next tick.
- R2: Data bits follow the start bit least significant bit first. The count equals `cfg_len`, and data bits above that count are never sent.
- R3: `cfg_par` selects the parity mode: 2'b00 none, 2'b10 even, 2'b11 odd, and 2'b01 acts as none. When parity is on, exactly one parity bit sits between the last data bit and the first stop bit.
- R4: The parity bit is the XOR of the transmitted data bits. In odd mode that value is inverted.
- R5: The frame ends with one high stop bit when `cfg_two_stop` is 0, and with two high stop bits when it is 1.
- R6: When no frame is being sent, `tx` is high.
- R7: A character accepted during the final stop bit starts its frame immediately after that stop bit, with no idle bit between the two frames.
- R8: `in_ready` is high only while idle or during the final stop bit of a frame, and it falls in the cycle after an accept.
- R9: The data and the format are captured when a character is accepted. Later changes to `in_data` or the configuration inputs do not alter that frame.
- R10: `tx` changes only on clock edges where `bit_tick` was high. Reset drives `tx` high and leaves `in_ready` high.
- R11: A `cfg_len` below 5 is treated as 5, and a `cfg_len` above `DATA_W` is treated as `DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle enable marking each bit boundary |
| in_valid | input | 1 | Host offers a character |
| in_ready | output | 1 | Block accepts the character in this cycle |
| in_data | input | DATA_W | Character, bit 0 sent first |
| cfg_len | input | $clog2(DATA_W+1) | Number of data bits |
| cfg_par | input | 2 | Parity mode (00 none, 10 even, 11 odd, 01 none) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx | output | 1 | Serial line, high when idle |

## Verification
The bench builds the block with DATA_W=9, MIN_W=5 and the ripple-chain parity variant (PAR_STYLE=1). That setting makes the full 9-bit character reachable, along with both clamp limits and odd parity over nine bits. The default tree variant is covered only by elaboration. The ticks arrive every fourth clock, which leaves room to check that `tx` holds between ticks. It also lets the bench accept a character on a cycle with no tick while the line is still in its last stop bit.

// File: rtl/atx_pkg.sv
package atx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_PAR   = 3'd3,
      PH_STOP1 = 3'd4,
      PH_STOP2 = 3'd5
   } phase_t;

   typedef enum logic [1:0] {
      PM_NONE = 2'b00,
      PM_RSVD = 2'b01,
      PM_EVEN = 2'b10,
      PM_ODD  = 2'b11
   } par_mode_t;

   localparam int PAR_TREE  = 0;
   localparam int PAR_CHAIN = 1;

endpackage

// File: rtl/atx_fmt.sv
module atx_fmt #(
   parameter int DATA_W = 9,
   parameter int MIN_W  = 5,
   parameter int LEN_W  = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] raw_data,
   input  logic [LEN_W-1:0]  raw_len,
   input  logic [1:0]        raw_par,
   output logic [DATA_W-1:0] norm_data,
   output logic [LEN_W-1:0]  norm_len,
   output logic              par_en,
   output logic              par_odd
);
   import atx_pkg::*;

   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_W);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DATA_W);

   always_comb begin
      if (raw_len < LEN_LO)
         norm_len = LEN_LO;
      else if (raw_len > LEN_HI)
         norm_len = LEN_HI;
      else
         norm_len = raw_len;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < MIN_W) begin : g_always
         assign norm_data[i] = raw_data[i];
      end else begin : g_cond
         assign norm_data[i] = raw_data[i] & (norm_len > LEN_W'(i));
      end
   end

   always_comb begin
      case (par_mode_t'(raw_par))
         PM_EVEN: begin par_en = 1'b1; par_odd = 1'b0; end
         PM_ODD:  begin par_en = 1'b1; par_odd = 1'b1; end
         default: begin par_en = 1'b0; par_odd = 1'b0; end
      endcase
   end

endmodule

// File: rtl/atx_parity.sv
module atx_parity #(
   parameter int W     = 9,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] bits,
   input  logic         odd,
   output logic         par
);
   import atx_pkg::*;

   logic sum;

   if (STYLE == PAR_TREE) begin : g_tree
      assign sum = ^bits;
   end else begin : g_chain
      logic [W:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_stage
         assign acc[i+1] = acc[i] ^ bits[i];
      end
      assign sum = acc[W];
   end

   assign par = sum ^ odd;

endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         set,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         full
);

   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         q    <= '0;
      end else if (set) begin
         full <= 1'b1;
         q    <= d;
      end else if (clr) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/atx_frame.sv
module atx_frame #(
   parameter int DATA_W = 9,
   parameter int LEN_W  = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              have,
   input  logic [DATA_W-1:0] s_data,
   input  logic [LEN_W-1:0]  s_len,
   input  logic              s_par_en,
   input  logic              s_par_bit,
   input  logic              s_two,
   output logic              tx,
   output logic              idle,
   output logic              last_stop,
   output logic              launch
);
   import atx_pkg::*;

   phase_t            phase;
   logic [DATA_W-1:0] shreg;
   logic [LEN_W-1:0]  cnt;
   logic [LEN_W-1:0]  len_q;
   logic              par_en_q;
   logic              par_q;
   logic              two_q;
   logic              tx_q;

   assign idle      = (phase == PH_IDLE);
   assign last_stop = (phase == PH_STOP2) || ((phase == PH_STOP1) && !two_q);
   assign launch    = tick && have && (idle || last_stop);
   assign tx        = tx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= PH_IDLE;
         tx_q     <= 1'b1;
         shreg    <= '0;
         cnt      <= '0;
         len_q    <= '0;
         par_en_q <= 1'b0;
         par_q    <= 1'b0;
         two_q    <= 1'b0;
      end else if (launch) begin
         phase    <= PH_START;
         tx_q     <= 1'b0;
         shreg    <= s_data;
         cnt      <= '0;
         len_q    <= s_len;
         par_en_q <= s_par_en;
         par_q    <= s_par_bit;
         two_q    <= s_two;
      end else if (tick) begin
         case (phase)
            PH_START: begin
               tx_q  <= shreg[0];
               shreg <= shreg >> 1;
               cnt   <= LEN_W'(1);
               phase <= PH_DATA;
            end
            PH_DATA: begin
               if (cnt == len_q) begin
                  if (par_en_q) begin
                     tx_q  <= par_q;
                     phase <= PH_PAR;
                  end else begin
                     tx_q  <= 1'b1;
                     phase <= PH_STOP1;
                  end
               end else begin
                  tx_q  <= shreg[0];
                  shreg <= shreg >> 1;
                  cnt   <= cnt + LEN_W'(1);
               end
            end
            PH_PAR: begin
               tx_q  <= 1'b1;
               phase <= PH_STOP1;
            end
            PH_STOP1: begin
               tx_q  <= 1'b1;
               phase <= two_q ? PH_STOP2 : PH_IDLE;
            end
            PH_STOP2: begin
               tx_q  <= 1'b1;
               phase <= PH_IDLE;
            end
            default: begin
               tx_q  <= 1'b1;
               phase <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/async_tx.sv
module async_tx #(
   parameter int DATA_W    = 9,
   parameter int MIN_W     = 5,
   parameter int PAR_STYLE = 0,
   localparam int LEN_W    = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_two_stop,
   output logic              tx
);
   import atx_pkg::*;

   localparam int HW = DATA_W + LEN_W + 3;

   if (MIN_W < 1 || DATA_W < MIN_W) begin : g_bad_width
      $error("async_tx: need 1 <= MIN_W <= DATA_W");
   end
   if (PAR_STYLE != PAR_TREE && PAR_STYLE != PAR_CHAIN) begin : g_bad_style
      $error("async_tx: PAR_STYLE must be 0 or 1");
   end

   logic [DATA_W-1:0] n_data;
   logic [LEN_W-1:0]  n_len;
   logic              n_par_en;
   logic              n_par_odd;
   logic              n_par_bit;
   logic [HW-1:0]     in_vec;
   logic [HW-1:0]     hold_q;
   logic [HW-1:0]     src;
   logic              full;
   logic              take;
   logic              launch;
   logic              idle;
   logic              last_stop;

   atx_fmt #(.DATA_W(DATA_W), .MIN_W(MIN_W), .LEN_W(LEN_W)) u_fmt (
      .raw_data  (in_data),
      .raw_len   (cfg_len),
      .raw_par   (cfg_par),
      .norm_data (n_data),
      .norm_len  (n_len),
      .par_en    (n_par_en),
      .par_odd   (n_par_odd)
   );

   atx_parity #(.W(DATA_W), .STYLE(PAR_STYLE)) u_par (
      .bits (n_data),
      .odd  (n_par_odd),
      .par  (n_par_bit)
   );

   assign in_vec   = {n_data, n_len, n_par_en, n_par_bit, cfg_two_stop};
   assign in_ready = !full && (idle || last_stop);
   assign take     = in_valid && in_ready;
   assign src      = full ? hold_q : in_vec;

   atx_hold #(.W(HW)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .set  (take && !launch),
      .clr  (launch),
      .d    (in_vec),
      .q    (hold_q),
      .full (full)
   );

   atx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
      .clk       (clk),
      .rst       (rst),
      .tick      (bit_tick),
      .have      (full || take),
      .s_data    (src[HW-1 -: DATA_W]),
      .s_len     (src[LEN_W+2 -: LEN_W]),
      .s_par_en  (src[2]),
      .s_par_bit (src[1]),
      .s_two     (src[0]),
      .tx        (tx),
      .idle      (idle),
      .last_stop (last_stop),
      .launch    (launch)
   );

endmodule

// File: rtl/atx_chk.sv
module atx_chk (
   input logic clk,
   input logic rst,
   input logic bit_tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx
);

   AST_TX_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !bit_tick |=> $stable(tx)) else $error("tx moved without tick"); // R10

   AST_READY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> tx) else $error("ready while line low"); // R8

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready) else $error("ready held after accept"); // R8

   AST_TICK_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && bit_tick) |=> !tx) else $error("no start bit"); // R1

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid && bit_tick) |=> tx) else $error("line low with nothing sent"); // R6

endmodule

bind async_tx atx_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .bit_tick (bit_tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tx       (tx)
);

// File: tb/async_tx_test.sv
`timescale 1ns/100ps
module async_tx_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [8:0] in_data = '0;
   logic [3:0] cfg_len = 4'd8;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_two_stop = 1'b0;
   logic       tx;

   int tests = 0;
   int fails = 0;
   int glitches = 0;
   logic lg [0:4095];
   int nlog = 0;
   logic ex [0:63];
   int en = 0;

   async_tx #(.DATA_W(9), .MIN_W(5), .PAR_STYLE(1)) uut (
      .clk(clk), .rst(rst), .bit_tick(bit_tick), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
      .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .tx(tx)
   );

   initial forever #2 clk = ~clk;

   initial begin
      int tc;
      tc = 0;
      forever begin
         @(negedge clk);
         bit_tick = (tc == 3);
         tc = (tc + 1) % 4;
      end
   end

   always @(posedge clk) begin
      logic t, p, r;
      t = bit_tick; p = tx; r = rst;
      #1;
      if (!r) begin
         if (t) begin
            if (nlog < 4096) begin lg[nlog] = tx; nlog++; end
         end else if (tx !== p) glitches++;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      summary();
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic add_frame(input logic [8:0] d, input int len, input logic [1:0] pm, input logic two);
      int eff;
      logic p;
      eff = (len < 5) ? 5 : ((len > 9) ? 9 : len);
      ex[en] = 1'b0; en++;
      p = 1'b0;
      for (int i = 0; i < eff; i++) begin ex[en] = d[i]; en++; p ^= d[i]; end
      if (pm[1]) begin ex[en] = p ^ pm[0]; en++; end
      ex[en] = 1'b1; en++;
      if (two) begin ex[en] = 1'b1; en++; end
   endtask

   task automatic send(input logic [8:0] d, input int len, input logic [1:0] pm, input logic two);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; cfg_len = 4'(len); cfg_par = pm; cfg_two_stop = two;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   function automatic int find_start(input int mark);
      for (int i = mark; i < nlog; i++) if (lg[i] === 1'b0) return i;
      return -1;
   endfunction

   task automatic check_frames(input int mark, input string req);
      int s, guard, bad;
      logic a, e;
      s = -1; guard = 0;
      while (guard < 3000) begin
         @(negedge clk);
         s = find_start(mark);
         if (s >= 0 && nlog >= s + en + 1) break;
         guard++;
      end
      tests++;
      if (s < 0 || nlog < s + en + 1) begin
         fails++;
         $display("FAIL %s: actual frame missing, expected %0d bits", req, en);
         return;
      end
      bad = -1;
      for (int k = 0; k <= en; k++) begin
         e = (k == en) ? 1'b1 : ex[k];
         if (lg[s+k] !== e && bad < 0) begin bad = k; a = lg[s+k]; end
      end
      if (bad >= 0) begin
         fails++;
         e = (bad == en) ? 1'b1 : ex[bad];
         $display("FAIL %s: bit %0d actual %b expected %b", req, bad, a, e);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R10 reset tx", 32'(tx), 32'd1);
      check("R10 reset ready", 32'(in_ready), 32'd1);
      repeat (12) @(negedge clk);
      check("R6 idle line", 32'(tx), 32'd1);
   endtask

   task automatic t_single(input logic [8:0] d, input int len, input logic [1:0] pm,
                           input logic two, input string req);
      int mark;
      mark = nlog; en = 0;
      add_frame(d, len, pm, two);
      send(d, len, pm, two);
      check_frames(mark, req);
   endtask

   task automatic t_back_to_back();
      int mark;
      mark = nlog; en = 0;
      add_frame(9'h0C3, 8, 2'b10, 1'b0);
      add_frame(9'h155, 7, 2'b11, 1'b1);
      add_frame(9'h01E, 5, 2'b00, 1'b0);
      send(9'h0C3, 8, 2'b10, 1'b0);
      send(9'h155, 7, 2'b11, 1'b1);
      send(9'h01E, 5, 2'b00, 1'b0);
      check_frames(mark, "R7 back-to-back frames");
   endtask

   task automatic t_ready_window();
      int mark, s, guard;
      mark = nlog; en = 0;
      add_frame(9'h0A6, 6, 2'b10, 1'b1);
      send(9'h0A6, 6, 2'b10, 1'b1);
      s = -1; guard = 0;
      while ((s < 0 || nlog < s + 3) && guard < 2000) begin
         @(negedge clk); s = find_start(mark); guard++;
      end
      check("R8 ready low mid-frame", 32'(in_ready), 32'd0);
      guard = 0;
      while (nlog < s + en && guard < 2000) begin @(negedge clk); guard++; end
      check("R8 ready high in last stop", 32'(in_ready), 32'd1);
      check_frames(mark, "R5 two stop frame");
   endtask

   task automatic t_cfg_change();
      int mark, s, guard;
      mark = nlog; en = 0;
      add_frame(9'h096, 8, 2'b10, 1'b0);
      send(9'h096, 8, 2'b10, 1'b0);
      in_data = 9'h1FF; cfg_len = 4'd5; cfg_par = 2'b11; cfg_two_stop = 1'b1;
      s = -1; guard = 0;
      while ((s < 0 || nlog < s + 4) && guard < 2000) begin
         @(negedge clk); s = find_start(mark); guard++;
      end
      in_data = 9'h000; cfg_len = 4'd9; cfg_par = 2'b00;
      check_frames(mark, "R9 format latched");
   endtask

   initial begin
      t_reset();
      t_single(9'h0A5, 8, 2'b00, 1'b0, "R2 8-bit no parity");
      t_single(9'h1F5, 5, 2'b10, 1'b0, "R3 5-bit even, upper bits unsent");
      t_single(9'h05B, 7, 2'b11, 1'b0, "R4 7-bit odd");
      t_single(9'h1B3, 9, 2'b11, 1'b1, "R5 9-bit odd two stop");
      t_single(9'h1FF, 9, 2'b10, 1'b0, "R4 9-bit all ones even");
      t_single(9'h000, 6, 2'b11, 1'b0, "R1 6-bit zeros odd");
      t_single(9'h0E7, 8, 2'b01, 1'b0, "R3 mode 01 acts as none");
      t_single(9'h1ED, 2, 2'b10, 1'b0, "R11 length below 5 clamps");
      t_single(9'h1A9, 15, 2'b00, 1'b1, "R11 length above 9 clamps");
      t_back_to_back();
      t_ready_window();
      t_cfg_change();
      repeat (20) @(negedge clk);
      check("R6 idle after frames", 32'(tx), 32'd1);
      check("R10 no change off tick", 32'(glitches), 32'd0);
      summary();
      $finish;
   end

endmodule